// File: doc/BRIEF.md
# Serial Controller Configuration Space Responder

This block answers configuration accesses for a serial controller that is compatible with a 16550. It holds a 256-byte type-0 configuration header and sees it as 64 dwords. A simple register port reaches the header. Each access carries a dword index, 32 bits of write data, four byte enables and one read strobe or one write strobe. Read data is registered. It shows up on the cycle after the read strobe and then holds until the next read.

The header presents a fixed identity that software cannot change. It also holds the interrupt line byte, which software can write. It serves one or two I/O base address registers, each covering an 8-byte window, and each supports the usual all-ones probe that software uses to learn the window size. The static parameter `NUM_PORTS` selects a one-port or a two-port variant. In the one-port variant the second base address register is inert. The remaining base address slots, the command and status words, the capability pointer and every unlisted offset are read-only.

Top module: `cfg_space_resp`

## Requirements
- R1: After reset, BAR0 (dword index 4) reads 0x00000001. BAR1 (index 5) reads 0x00000001 in the two-port variant. The interrupt line byte (byte 0 of index 15) reads 0x00.
- R2: Dword index 0 and dword index 11 each read 0x32534348. Dword index 2 reads 0x07000210, which holds class 0x07, subclass 0x00, interface 0x02 and revision 0x10. Writes never change these values.
- R3: Dword index 1 always reads 0x02000001, with status 0x0200 in the upper half and command 0x0001 in the lower half. Writes to it are ignored.
- R4: In dword index 15, byte 0 is the interrupt line and is written when byte enable 0 is set. Byte 1 is the interrupt pin: it always reads 0x01 and ignores writes. Bytes 2 and 3 read zero.
- R5: A write of 0xFFFFFFFF with all four byte enables set to an active BAR stores 0xFFFFFFF9. This value is the 8-byte size mask 0xFFFFFFF8 with the BAR's low two bits kept.
- R6: Any other write to an active BAR first merges the enabled bytes into the current value. Bits 31:2 of that merged value are then stored, and bits 1:0 keep their previous value of 01.
- R7: In the one-port variant, BAR1 always reads zero. In both variants, dword indices 6, 7 and 8 (BAR2 to BAR4) always read zero.
- R8: The capability pointer (dword index 13) and every offset not listed above read zero and ignore writes.
- R9: rdata_o takes the addressed value one clock after a cycle with rd_i high. It holds its value in every cycle without rd_i, and writes do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Dword index into the 256-byte header |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables for the write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |

## Verification
The hardest behaviour to reach from the ports is a BAR write where partial byte enables merge with a value left by an earlier probe or address write. The stored result then depends on history, not on the current write alone. To reach it, the stimulus runs a long random mix of writes to BAR0 and BAR1. The data is biased toward all-ones, and the byte enables are drawn at random. These writes are interleaved with reads of the same BARs, and both variants receive identical traffic side by side. Directed steps cover the exact sizing probe, probes made with partial enables, and writes to read-only words followed by reads.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 6;
  localparam int unsigned BW = DW / 8;

  typedef enum logic [AW-1:0] {
    IDX_ID     = 6'h00,
    IDX_CMDSTS = 6'h01,
    IDX_CLASS  = 6'h02,
    IDX_BAR0   = 6'h04,
    IDX_BAR1   = 6'h05,
    IDX_SUBSYS = 6'h0B,
    IDX_INTR   = 6'h0F
  } cfg_idx_e;

  localparam logic [DW-1:0] ID_WORD     = 32'h3253_4348;
  localparam logic [DW-1:0] CMDSTS_WORD = 32'h0200_0001;
  localparam logic [DW-1:0] CLASS_WORD  = 32'h0700_0210;
  localparam logic [7:0]    INT_PIN     = 8'h01;
  localparam logic [DW-1:0] BAR_IO_INIT = 32'h0000_0001;

  function automatic logic [DW-1:0] byte_merge(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] nxt,
                                               input logic [BW-1:0] be);
    logic [DW-1:0] r;
    r = cur;
    for (int i = 0; i < int'(BW); i++)
      if (be[i]) r[8*i +: 8] = nxt[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cfg_bar_reg.sv
module cfg_bar_reg
  import cfg_space_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [BW-1:0] be_i,
  output logic [DW-1:0] q_o
);
  localparam logic [DW-1:0] SIZE_MASK = ~(DW'(WIN_BYTES) - 1'b1);

  logic [DW-1:0] merged;
  logic          probe;
  logic [DW-1:0] nxt;

  always_comb begin
    merged = byte_merge(q_o, wdata_i, be_i);
    probe  = (be_i == '1) && (wdata_i == '1);
    if (probe) nxt = (merged & SIZE_MASK) | {30'd0, q_o[1:0]};
    else       nxt = {merged[DW-1:2], q_o[1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= BAR_IO_INIT;
    else if (we_i) q_o <= nxt;
  end
endmodule

// File: rtl/cfg_intr_reg.sv
module cfg_intr_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wbyte_i,
  output logic [7:0] line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   line_o <= 8'h00;
    else if (we_i) line_o <= wbyte_i;
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_space_pkg::*;
#(
  parameter int unsigned NBAR = 2
) (
  input  logic [AW-1:0]          idx_i,
  input  logic [NBAR-1:0][DW-1:0] bar_i,
  input  logic [7:0]             int_line_i,
  output logic [DW-1:0]          word_o
);
  always_comb begin
    word_o = '0;
    case (idx_i)
      IDX_ID, IDX_SUBSYS: word_o = ID_WORD;
      IDX_CMDSTS:         word_o = CMDSTS_WORD;
      IDX_CLASS:          word_o = CLASS_WORD;
      IDX_BAR0:           word_o = bar_i[0];
      IDX_BAR1:           word_o = bar_i[1];
      IDX_INTR:           word_o = {16'h0000, INT_PIN, int_line_i};
      default:            word_o = '0;
    endcase
  end
endmodule

// File: rtl/cfg_space_resp.sv
module cfg_space_resp
  import cfg_space_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned WIN_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [5:0]    addr_i,
  input  logic [31:0]   wdata_i,
  input  logic [3:0]    be_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [31:0]   rdata_o
);
  localparam int unsigned NBAR = 2;

  logic [NBAR-1:0][DW-1:0] bar_q;
  logic [7:0]              int_line;
  logic [DW-1:0]           rd_word;

  for (genvar b = 0; b < NBAR; b++) begin : g_bar
    if (b < NUM_PORTS) begin : g_on
      cfg_bar_reg #(.WIN_BYTES(WIN_BYTES)) i_bar (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_i && (addr_i == AW'(IDX_BAR0) + AW'(b))),
        .wdata_i (wdata_i),
        .be_i    (be_i),
        .q_o     (bar_q[b])
      );
    end else begin : g_off
      assign bar_q[b] = '0;
    end
  end

  cfg_intr_reg i_intr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i && be_i[0] && (addr_i == IDX_INTR)),
    .wbyte_i (wdata_i[7:0]),
    .line_o  (int_line)
  );

  cfg_read_mux #(.NBAR(NBAR)) i_mux (
    .idx_i      (addr_i),
    .bar_i      (bar_q),
    .int_line_i (int_line),
    .word_o     (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_word;
  end
endmodule

// File: rtl/cfg_space_resp_chk.sv
module cfg_space_resp_chk #(
  parameter int unsigned NUM_PORTS = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [5:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [3:0]  be_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [31:0] rdata_o,
  input logic [31:0] bar0_q,
  input logic [31:0] bar1_q
);
  logic probe;
  assign probe = (be_i == 4'hF) && (wdata_i == 32'hFFFF_FFFF);

  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  // R2
  id_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 6'h00) |=> rdata_o == 32'h3253_4348);
  // R3
  cmdsts_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 6'h01) |=> rdata_o == 32'h0200_0001);
  // R4
  int_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 6'h0F) |=> rdata_o[31:8] == 24'h00_0001);
  // R5
  bar0_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 6'h04 && probe) |=> bar0_q == 32'hFFFF_FFF9);
  // R5
  bar1_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NUM_PORTS == 2 && wr_i && addr_i == 6'h05 && probe) |=> bar1_q == 32'hFFFF_FFF9);
  // R6
  bar0_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 6'h04 && !probe) |=> bar0_q[1:0] == 2'b01);
  // R7
  bar1_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NUM_PORTS == 1 && rd_i && addr_i == 6'h05) |=> rdata_o == 32'h0);
endmodule

bind cfg_space_resp cfg_space_resp_chk #(.NUM_PORTS(NUM_PORTS)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .be_i    (be_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .rdata_o (rdata_o),
  .bar0_q  (bar_q[0]),
  .bar1_q  (bar_q[1])
);

// File: tb/test_cfg_space_resp.sv
module test_cfg_space_resp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] rdata2, rdata1;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  logic [31:0] m_bar0, m_bar1;
  logic [7:0]  m_line;

  always #2.5 clk = ~clk;

  cfg_space_resp #(.NUM_PORTS(2)) i_cfg_space_resp (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata2));

  cfg_space_resp #(.NUM_PORTS(1)) i_cfg_space_resp_one (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata1));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  function automatic logic [31:0] bar_next(logic [31:0] cur, logic [31:0] d, logic [3:0] e);
    logic [31:0] m;
    m = cur;
    for (int i = 0; i < 4; i++) if (e[i]) m[8*i +: 8] = d[8*i +: 8];
    if (e == 4'hF && d == 32'hFFFF_FFFF) return 32'hFFFF_FFF9;
    return {m[31:2], cur[1:0]};
  endfunction

  function automatic logic [31:0] exp_word(bit one_port, logic [5:0] a);
    case (a)
      6'h00, 6'h0B: return 32'h3253_4348;
      6'h01:        return 32'h0200_0001;
      6'h02:        return 32'h0700_0210;
      6'h04:        return m_bar0;
      6'h05:        return one_port ? 32'h0 : m_bar1;
      6'h0F:        return {16'h0, 8'h01, m_line};
      default:      return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [5:0] a, logic [31:0] d, logic [3:0] e);
    @(negedge clk);
    addr = a; wdata = d; be = e; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (a == 6'h04) m_bar0 = bar_next(m_bar0, d, e);
    if (a == 6'h05) m_bar1 = bar_next(m_bar1, d, e);
    if (a == 6'h0F && e[0]) m_line = d[7:0];
  endtask

  task automatic do_read(logic [5:0] a, string req);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(req, rdata2, exp_word(1'b0, a));
    chk(req, rdata1, exp_word(1'b1, a));
  endtask

  function automatic string req_of(logic [5:0] a);
    case (a)
      6'h00, 6'h02, 6'h0B: return "R2";
      6'h01:               return "R3";
      6'h04:               return "R6";
      6'h05, 6'h06, 6'h07, 6'h08: return "R7";
      6'h0F:               return "R4";
      default:             return "R8";
    endcase
  endfunction

  initial begin
    logic [31:0] hold;
    m_bar0 = 32'h1; m_bar1 = 32'h1; m_line = 8'h00;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R9", rdata2, 32'h0);
    rst_n = 1'b1;
    // R1 reset defaults
    do_read(6'h04, "R1");
    do_read(6'h05, "R1");
    do_read(6'h0F, "R1");
    // R2 identity, writes ignored
    do_write(6'h00, 32'h0, 4'hF);
    do_write(6'h02, 32'hDEAD_BEEF, 4'hF);
    do_read(6'h00, "R2"); do_read(6'h02, "R2"); do_read(6'h0B, "R2");
    // R3 command/status read-only
    do_write(6'h01, 32'h0000_0006, 4'hF);
    do_read(6'h01, "R3");
    // R4 line writable, pin not
    do_write(6'h0F, 32'hFFFF_AB5A, 4'hF);
    do_read(6'h0F, "R4");
    do_write(6'h0F, 32'h0000_0033, 4'hE);
    do_read(6'h0F, "R4");
    // R5 sizing probe
    do_write(6'h04, 32'hFFFF_FFFF, 4'hF);
    do_read(6'h04, "R5");
    do_write(6'h05, 32'hFFFF_FFFF, 4'hF);
    do_read(6'h05, "R5");
    // R6 address write and partial-enable probe
    do_write(6'h04, 32'h0000_C0A2, 4'hF);
    do_read(6'h04, "R6");
    do_write(6'h04, 32'hFFFF_FFFF, 4'h3);
    do_read(6'h04, "R6");
    // R7 inert BARs
    do_write(6'h05, 32'h0000_1000, 4'hF);
    do_read(6'h05, "R7");
    do_write(6'h06, 32'hFFFF_FFFF, 4'hF);
    do_read(6'h06, "R7"); do_read(6'h08, "R7");
    // R8 cap pointer and unlisted
    do_write(6'h0D, 32'h0000_0040, 4'hF);
    do_read(6'h0D, "R8");
    do_write(6'h30, 32'h1234_5678, 4'hF);
    do_read(6'h30, "R8");
    // R9 hold without read strobe
    do_read(6'h04, "R9");
    hold = exp_word(1'b0, 6'h04);
    do_write(6'h04, 32'h0000_2000, 4'hF);
    repeat (3) @(negedge clk);
    chk("R9", rdata2, hold);
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [5:0] a;
      logic [31:0] d;
      logic [3:0] e;
      case ($urandom_range(0, 3))
        0: a = 6'h04;
        1: a = 6'h05;
        2: a = 6'h0F;
        default: a = 6'($urandom_range(0, 63));
      endcase
      d = ($urandom_range(0, 2) == 0) ? 32'hFFFF_FFFF : $urandom;
      e = ($urandom_range(0, 1) == 0) ? 4'hF : 4'($urandom);
      if ($urandom_range(0, 1) == 0) do_write(a, d, e);
      else do_read(a, req_of(a));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule